// File: doc/BRIEF.md
# SIMD Saturating and Averaging Lane Arithmetic Unit

This block is a vector integer datapath for a SIMD execution pipe. It takes two 128-bit source vectors, a 2-bit lane-format code and a 5-bit operation code. The format code cuts both vectors into equal lanes of 8, 16, 32 or 64 bits. The selected operation is then applied to each lane pair on its own, and no carry or saturation crosses a lane boundary.

The operations are saturating add and subtract in signed, unsigned and two mixed-sign forms, add of absolute values (wrapping and clamped), truncating and rounding averages, absolute difference, and max/min by signed value, unsigned value or magnitude. Integer divide and remainder are also included, and their corner cases give fixed results instead of a trap. A one-cycle `start_i` pulse captures the computed vector into the result register. `valid_o` marks the cycle in which that result appears. Register access, decode and exception handling belong to the surrounding pipeline.

Top module: `simd_sat_alu`

## Requirements
- R1: The result register is loaded, and `valid_o` is high, in the cycle after `start_i` is sampled high. `valid_o` is low after any cycle without `start_i`, and `result_o` then holds its value.
- R2: `fmt_i` 0/1/2/3 selects lanes of 8/16/32/64 bits. Lane i occupies bits [i*W +: W] of each vector, and lanes do not interact.
- R3: Codes 0 (signed add), 1 (unsigned add), 2 (signed subtract) and 3 (unsigned subtract) clamp the exact result to the lane's signed or unsigned range.
- R4: Code 4 computes unsigned a minus signed b, clamped to [0, 2^W-1]. Code 5 computes unsigned a minus unsigned b, clamped to the signed lane range.
- R5: Code 6 returns |a|+|b| modulo 2^W. Code 7 returns |a|+|b| clamped to the largest signed lane value.
- R6: Code 8 (signed) and code 9 (unsigned) return floor((a+b)/2). Code 10 (signed) and code 11 (unsigned) return floor((a+b+1)/2). None of these overflow.
- R7: Code 12 (signed compare) and code 13 (unsigned compare) return |a-b| as a W-bit unsigned value.
- R8: Codes 14/15 return the signed/unsigned maximum, and 16/17 the signed/unsigned minimum. Code 18 returns a when |a|>|b| and b otherwise. Code 19 returns a when |a|<|b| and b otherwise. Codes 18 and 19 return the operand itself, with its sign.
- R9: Codes 20/21 are signed/unsigned quotients, truncated toward zero. Codes 22/23 are the matching remainders, which take the dividend's sign.
- R10: A zero divisor gives 0 for codes 20 to 23. A signed lane minimum divided by -1 gives the lane minimum as quotient and 0 as remainder.
- R11: Codes 24 to 31 load an all-zero result.
- R12: While reset is asserted, `result_o` is 0 and `valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Capture the current operation into the result register |
| op_i | input | 5 | Operation code |
| fmt_i | input | 2 | Lane format code |
| src_a_i | input | 128 | First source vector |
| src_b_i | input | 128 | Second source vector |
| result_o | output | 128 | Registered result vector |
| valid_o | output | 1 | High for one cycle when a new result is present |

## Verification
The assertions check the timing on every cycle: each start produces exactly one valid cycle, and the result holds when no start is given. They also check value properties that do not depend on lane decoding. A zero divisor vector gives a zero result for all four divide and remainder codes, and unused codes clear the result. An unsigned maximum in the 64-bit format never comes out below either operand. The arithmetic of each code in each lane width shows only in the bench scenarios. These compare every lane with an independent wide-integer model, using random operands mixed with 0, -1, 1 and the signed minimum and maximum. Directed vectors cover the clamp edges, the rounding direction of the averages, magnitude ties and the divide corner cases.

// File: rtl/simd_sat_pkg.sv
package simd_sat_pkg;

  typedef enum logic [4:0] {
    OP_ADDS_S   = 5'd0,
    OP_ADDS_U   = 5'd1,
    OP_SUBS_S   = 5'd2,
    OP_SUBS_U   = 5'd3,
    OP_SUB_US   = 5'd4,
    OP_SUB_UUS  = 5'd5,
    OP_ADD_MAG  = 5'd6,
    OP_ADDS_MAG = 5'd7,
    OP_AVG_S    = 5'd8,
    OP_AVG_U    = 5'd9,
    OP_AVGR_S   = 5'd10,
    OP_AVGR_U   = 5'd11,
    OP_ADIF_S   = 5'd12,
    OP_ADIF_U   = 5'd13,
    OP_MAX_S    = 5'd14,
    OP_MAX_U    = 5'd15,
    OP_MIN_S    = 5'd16,
    OP_MIN_U    = 5'd17,
    OP_MAX_MAG  = 5'd18,
    OP_MIN_MAG  = 5'd19,
    OP_DIV_S    = 5'd20,
    OP_DIV_U    = 5'd21,
    OP_REM_S    = 5'd22,
    OP_REM_U    = 5'd23
  } simd_op_e;

  localparam int OP_W       = 5;
  localparam int FMT_W      = 2;
  localparam int LANE_MIN_W = 8;

endpackage

// File: rtl/simd_sat_lane.sv
module simd_sat_lane
  import simd_sat_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [OP_W-1:0] op,
  input  logic [W-1:0]    a,
  input  logic [W-1:0]    b,
  output logic [W-1:0]    y
);

  // Two guard bits hold any exact sum or difference of two lane values.
  localparam int X = W + 2;
  localparam logic signed [X-1:0] ZERO = '0;
  localparam logic signed [X-1:0] ONE  = X'(1);
  localparam logic signed [X-1:0] SMAX = {3'b000, {(W-1){1'b1}}};
  localparam logic signed [X-1:0] SMIN = {3'b111, {(W-1){1'b0}}};
  localparam logic signed [X-1:0] UMAX = {2'b00, {W{1'b1}}};

  logic signed [X-1:0] sa, sb, ua, ub, mag_a, mag_b;

  function automatic logic signed [X-1:0] clip(input logic signed [X-1:0] v,
                                               input logic signed [X-1:0] lo,
                                               input logic signed [X-1:0] hi);
    if (v < lo)      return lo;
    else if (v > hi) return hi;
    else             return v;
  endfunction

  always_comb begin
    sa    = {{2{a[W-1]}}, a};
    sb    = {{2{b[W-1]}}, b};
    ua    = {2'b00, a};
    ub    = {2'b00, b};
    mag_a = (sa < ZERO) ? -sa : sa;
    mag_b = (sb < ZERO) ? -sb : sb;
  end

  always_comb begin
    case (op)
      OP_ADDS_S:   y = W'(clip(sa + sb, SMIN, SMAX));
      OP_ADDS_U:   y = W'(clip(ua + ub, ZERO, UMAX));
      OP_SUBS_S:   y = W'(clip(sa - sb, SMIN, SMAX));
      OP_SUBS_U:   y = W'(clip(ua - ub, ZERO, UMAX));
      OP_SUB_US:   y = W'(clip(ua - sb, ZERO, UMAX));
      OP_SUB_UUS:  y = W'(clip(ua - ub, SMIN, SMAX));
      OP_ADD_MAG:  y = W'(mag_a + mag_b);
      OP_ADDS_MAG: y = W'(clip(mag_a + mag_b, ZERO, SMAX));
      OP_AVG_S:    y = W'((sa + sb) >>> 1);
      OP_AVG_U:    y = W'((ua + ub) >>> 1);
      OP_AVGR_S:   y = W'((sa + sb + ONE) >>> 1);
      OP_AVGR_U:   y = W'((ua + ub + ONE) >>> 1);
      OP_ADIF_S:   y = W'((sa < sb) ? (sb - sa) : (sa - sb));
      OP_ADIF_U:   y = W'((ua < ub) ? (ub - ua) : (ua - ub));
      OP_MAX_S:    y = (sa > sb) ? a : b;
      OP_MAX_U:    y = (ua > ub) ? a : b;
      OP_MIN_S:    y = (sa < sb) ? a : b;
      OP_MIN_U:    y = (ua < ub) ? a : b;
      OP_MAX_MAG:  y = (mag_a > mag_b) ? a : b;
      OP_MIN_MAG:  y = (mag_a < mag_b) ? a : b;
      // Widened operands: min / -1 gives +2^(W-1), which wraps back to min;
      // min % -1 gives 0.
      OP_DIV_S:    y = (sb == ZERO) ? '0 : W'(sa / sb);
      OP_DIV_U:    y = (ub == ZERO) ? '0 : W'(ua / ub);
      OP_REM_S:    y = (sb == ZERO) ? '0 : W'(sa % sb);
      OP_REM_U:    y = (ub == ZERO) ? '0 : W'(ua % ub);
      default:     y = '0;
    endcase
  end

endmodule

// File: rtl/simd_sat_bank.sv
module simd_sat_bank
  import simd_sat_pkg::*;
#(
  parameter int DATA_W = 128,
  parameter int W      = 8
) (
  input  logic [OP_W-1:0]   op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y
);

  localparam int LANES = DATA_W / W;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    simd_sat_lane #(.W(W)) u_lane (
      .op (op),
      .a  (a[i*W +: W]),
      .b  (b[i*W +: W]),
      .y  (y[i*W +: W])
    );
  end

endmodule

// File: rtl/simd_sat_alu.sv
module simd_sat_alu
  import simd_sat_pkg::*;
#(
  parameter int DATA_W = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [4:0]        op_i,
  input  logic [1:0]        fmt_i,
  input  logic [DATA_W-1:0] src_a_i,
  input  logic [DATA_W-1:0] src_b_i,
  output logic [DATA_W-1:0] result_o,
  output logic              valid_o
);

  localparam int NUM_FMT = 1 << FMT_W;

  logic [1:0]        rst_sync_q;
  logic              rst_sync_n;
  logic [DATA_W-1:0] bank_y [NUM_FMT];
  logic [DATA_W-1:0] fmt_y;
  logic [DATA_W-1:0] res_d, res_q;
  logic              vld_d, vld_q;

  // Reset asserts at once and is released two clock edges later.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  for (genvar f = 0; f < NUM_FMT; f++) begin : g_fmt
    localparam int LW = LANE_MIN_W << f;
    simd_sat_bank #(.DATA_W(DATA_W), .W(LW)) u_bank (
      .op (op_i),
      .a  (src_a_i),
      .b  (src_b_i),
      .y  (bank_y[f])
    );
  end

  assign fmt_y = bank_y[fmt_i];

  always_comb begin
    res_d = res_q;
    if (start_i) res_d = fmt_y;
    vld_d = start_i;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      res_q <= '0;
      vld_q <= 1'b0;
    end else begin
      res_q <= res_d;
      vld_q <= vld_d;
    end
  end

  assign result_o = res_q;
  assign valid_o  = vld_q;

endmodule

// File: rtl/simd_sat_alu_chk.sv
module simd_sat_alu_chk
  import simd_sat_pkg::*;
#(
  parameter int DATA_W = 128
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [4:0]        op,
  input logic [1:0]        fmt,
  input logic [DATA_W-1:0] b,
  input logic [DATA_W-1:0] a,
  input logic [DATA_W-1:0] result,
  input logic              valid
);

  // R1
  a_r1_valid_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> valid);

  // R1
  a_r1_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !valid);

  // R1
  a_r1_result_held: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(result));

  // R10
  a_r10_zero_divisor: assert property (@(posedge clk) disable iff (!rst_n)
    (start && (op >= 5'(OP_DIV_S)) && (op <= 5'(OP_REM_U)) && (b == '0))
      |=> (result == '0));

  // R11
  a_r11_unused_code_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (start && (op > 5'(OP_REM_U))) |=> (result == '0));

  // R8
  a_r8_umax_not_below: assert property (@(posedge clk) disable iff (!rst_n)
    (start && (op == 5'(OP_MAX_U)) && (fmt == 2'd3))
      |=> ((result[63:0] >= $past(a[63:0])) && (result[63:0] >= $past(b[63:0]))));

endmodule

bind simd_sat_alu simd_sat_alu_chk #(.DATA_W(DATA_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_sync_n),
  .start  (start_i),
  .op     (op_i),
  .fmt    (fmt_i),
  .b      (src_b_i),
  .a      (src_a_i),
  .result (result_o),
  .valid  (valid_o)
);

// File: tb/simd_sat_alu_bench.sv
module simd_sat_alu_bench;
  import simd_sat_pkg::*;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_i = 1'b0;
  logic [4:0]   op_i = '0;
  logic [1:0]   fmt_i = '0;
  logic [127:0] src_a_i = '0;
  logic [127:0] src_b_i = '0;
  logic [127:0] result_o;
  logic         valid_o;

  int n_chk  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  simd_sat_alu u_simd_sat_alu (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .op_i     (op_i),
    .fmt_i    (fmt_i),
    .src_a_i  (src_a_i),
    .src_b_i  (src_b_i),
    .result_o (result_o),
    .valid_o  (valid_o)
  );

  typedef struct packed {
    logic [4:0]   op;
    logic [1:0]   fmt;
    logic [127:0] a;
    logic [127:0] b;
    logic [127:0] exp;
    logic [3:0]   req;
  } vec_t;

  localparam int NV = 31;
  localparam vec_t VECS [NV] = '{
    '{5'(OP_ADDS_S),   2'd0, {16{8'h7f}}, {16{8'h01}}, {16{8'h7f}}, 4'd3},   // R3
    '{5'(OP_ADDS_U),   2'd0, {16{8'hff}}, {16{8'h01}}, {16{8'hff}}, 4'd3},   // R3
    '{5'(OP_SUBS_S),   2'd1, {8{16'h8000}}, {8{16'h0001}}, {8{16'h8000}}, 4'd3}, // R3
    '{5'(OP_SUBS_U),   2'd2, {4{32'd5}}, {4{32'd9}}, 128'd0, 4'd3},          // R3
    '{5'(OP_SUB_US),   2'd0, {16{8'hf0}}, {16{8'hf0}}, {16{8'hff}}, 4'd4},   // R4
    '{5'(OP_SUB_US),   2'd0, {16{8'h10}}, {16{8'h20}}, 128'd0, 4'd4},        // R4
    '{5'(OP_SUB_UUS),  2'd0, {16{8'hff}}, {16{8'h00}}, {16{8'h7f}}, 4'd4},   // R4
    '{5'(OP_SUB_UUS),  2'd0, {16{8'h00}}, {16{8'hff}}, {16{8'h80}}, 4'd4},   // R4
    '{5'(OP_ADD_MAG),  2'd0, {16{8'h80}}, {16{8'h80}}, 128'd0, 4'd5},        // R5
    '{5'(OP_ADDS_MAG), 2'd0, {16{8'h80}}, {16{8'h01}}, {16{8'h7f}}, 4'd5},   // R5
    '{5'(OP_ADDS_MAG), 2'd0, {16{8'hfd}}, {16{8'h04}}, {16{8'h07}}, 4'd5},   // R5
    '{5'(OP_AVG_S),    2'd0, {16{8'hff}}, {16{8'h00}}, {16{8'hff}}, 4'd6},   // R6
    '{5'(OP_AVGR_S),   2'd0, {16{8'hff}}, {16{8'h00}}, 128'd0, 4'd6},        // R6
    '{5'(OP_AVG_U),    2'd0, {16{8'hff}}, {16{8'hfe}}, {16{8'hfe}}, 4'd6},   // R6
    '{5'(OP_AVGR_U),   2'd0, {16{8'hff}}, {16{8'hfe}}, {16{8'hff}}, 4'd6},   // R6
    '{5'(OP_ADIF_S),   2'd0, {16{8'h80}}, {16{8'h7f}}, {16{8'hff}}, 4'd7},   // R7
    '{5'(OP_ADIF_U),   2'd0, {16{8'h03}}, {16{8'h0a}}, {16{8'h07}}, 4'd7},   // R7
    '{5'(OP_MAX_S),    2'd0, {16{8'h80}}, {16{8'h7f}}, {16{8'h7f}}, 4'd8},   // R8
    '{5'(OP_MIN_U),    2'd0, {16{8'h80}}, {16{8'h7f}}, {16{8'h7f}}, 4'd8},   // R8
    '{5'(OP_MAX_MAG),  2'd0, {16{8'hfb}}, {16{8'h04}}, {16{8'hfb}}, 4'd8},   // R8
    '{5'(OP_MIN_MAG),  2'd0, {16{8'hfc}}, {16{8'h04}}, {16{8'h04}}, 4'd8},   // R8 tie
    '{5'(OP_MAX_U),    2'd3, {2{64'hffff_ffff_ffff_fffe}}, {2{64'd1}},
                             {2{64'hffff_ffff_ffff_fffe}}, 4'd8},            // R8
    '{5'(OP_DIV_S),    2'd0, {16{8'hf9}}, {16{8'h02}}, {16{8'hfd}}, 4'd9},   // R9
    '{5'(OP_REM_S),    2'd0, {16{8'hf9}}, {16{8'h02}}, {16{8'hff}}, 4'd9},   // R9
    '{5'(OP_REM_U),    2'd3, {2{64'd100}}, {2{64'd7}}, {2{64'd2}}, 4'd9},    // R9
    '{5'(OP_DIV_S),    2'd0, {16{8'h80}}, {16{8'hff}}, {16{8'h80}}, 4'd10},  // R10
    '{5'(OP_REM_S),    2'd0, {16{8'h80}}, {16{8'hff}}, 128'd0, 4'd10},       // R10
    '{5'(OP_DIV_U),    2'd2, {4{32'd77}}, 128'd0, 128'd0, 4'd10},            // R10
    '{5'(OP_DIV_S),    2'd3, {2{64'h8000_0000_0000_0000}}, {2{64'hffff_ffff_ffff_ffff}},
                             {2{64'h8000_0000_0000_0000}}, 4'd10},           // R10
    '{5'(OP_ADDS_U),   2'd1, {8{16'h00ff}}, {8{16'h0001}}, {8{16'h0100}}, 4'd2}, // R2
    '{5'd24,           2'd0, {16{8'h55}}, {16{8'h33}}, 128'd0, 4'd11}        // R11
  };

  task automatic check(input bit ok, input int req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Independent wide-integer model of one lane.
  function automatic logic signed [129:0] clampv(input logic signed [129:0] v,
                                                 input logic signed [129:0] lo,
                                                 input logic signed [129:0] hi);
    return (v < lo) ? lo : ((v > hi) ? hi : v);
  endfunction

  function automatic logic signed [129:0] floor_half(input logic signed [129:0] t);
    logic signed [129:0] two;
    two = 130'sd2;
    if (t < 0 && t[0]) return (t - 130'sd1) / two;
    return t / two;
  endfunction

  function automatic logic [63:0] ref_lane(input int op, input int w,
                                           input logic [63:0] a, input logic [63:0] b);
    logic [63:0] mask;
    logic signed [129:0] one, sa, sb, ua, ub, ma, mb, smx, smn, umx, r, q;
    mask = (w == 64) ? 64'hffff_ffff_ffff_ffff : ((64'd1 << w) - 64'd1);
    one = 130'sd1;
    ua = 130'(a & mask);
    ub = 130'(b & mask);
    sa = a[w-1] ? (ua - (one <<< w)) : ua;
    sb = b[w-1] ? (ub - (one <<< w)) : ub;
    ma = (sa < 0) ? -sa : sa;
    mb = (sb < 0) ? -sb : sb;
    smx = (one <<< (w-1)) - one;
    smn = -(one <<< (w-1));
    umx = (one <<< w) - one;
    case (op)
      0:  r = clampv(sa + sb, smn, smx);
      1:  r = clampv(ua + ub, 0, umx);
      2:  r = clampv(sa - sb, smn, smx);
      3:  r = clampv(ua - ub, 0, umx);
      4:  r = clampv(ua - sb, 0, umx);
      5:  r = clampv(ua - ub, smn, smx);
      6:  r = ma + mb;
      7:  r = clampv(ma + mb, 0, smx);
      8:  r = floor_half(sa + sb);
      9:  r = floor_half(ua + ub);
      10: r = floor_half(sa + sb + one);
      11: r = floor_half(ua + ub + one);
      12: r = (sa > sb) ? sa - sb : sb - sa;
      13: r = (ua > ub) ? ua - ub : ub - ua;
      14: r = (sa >= sb) ? sa : sb;
      15: r = (ua >= ub) ? ua : ub;
      16: r = (sa <= sb) ? sa : sb;
      17: r = (ua <= ub) ? ua : ub;
      18: r = (ma > mb) ? sa : sb;
      19: r = (ma < mb) ? sa : sb;
      20: r = (sb == 0) ? 0 : ((sa == smn && sb == -1) ? smn : sa / sb);
      21: r = (ub == 0) ? 0 : ua / ub;
      22: begin
        if (sb == 0 || (sa == smn && sb == -1)) r = 0;
        else begin q = sa / sb; r = sa - q * sb; end
      end
      23: begin
        if (ub == 0) r = 0;
        else begin q = ua / ub; r = ua - q * ub; end
      end
      default: r = 0;
    endcase
    return r[63:0] & mask;
  endfunction

  function automatic logic [127:0] ref_vec(input int op, input int fmt,
                                           input logic [127:0] a, input logic [127:0] b);
    int w;
    logic [127:0] res;
    logic [127:0] m;
    w = 8 << fmt;
    m = (w == 64) ? {64'd0, {64{1'b1}}} : ((128'd1 << w) - 128'd1);
    res = '0;
    for (int i = 0; i < 128 / w; i++) begin
      logic [63:0] la, lb, ly;
      la = 64'((a >> (i*w)) & m);
      lb = 64'((b >> (i*w)) & m);
      ly = ref_lane(op, w, la, lb);
      res |= (128'(ly) << (i*w));
    end
    return res;
  endfunction

  function automatic logic [63:0] pick(input int w);
    logic [63:0] mask;
    logic [63:0] rnd;
    int sel;
    mask = (w == 64) ? 64'hffff_ffff_ffff_ffff : ((64'd1 << w) - 64'd1);
    rnd = {$urandom, $urandom};
    sel = int'($urandom % 7);
    case (sel)
      0: return 64'd0;
      1: return mask;                                  // -1
      2: return 64'd1 << (w-1);                        // signed minimum
      3: return (64'd1 << (w-1)) - 64'd1;              // signed maximum
      4: return 64'd1;
      default: return rnd & mask;
    endcase
  endfunction

  function automatic logic [127:0] rand_vec(input int fmt);
    int w;
    logic [127:0] v;
    w = 8 << fmt;
    v = '0;
    for (int i = 0; i < 128 / w; i++) v |= (128'(pick(w)) << (i*w));
    return v;
  endfunction

  task automatic run_op(input logic [4:0] op, input logic [1:0] fmt,
                        input logic [127:0] a, input logic [127:0] b,
                        input logic [127:0] exp, input int req);
    @(negedge clk);
    op_i = op; fmt_i = fmt; src_a_i = a; src_b_i = b; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(valid_o == 1'b1, 1, "valid after start", 128'(valid_o), 128'd1);   // R1
    check(result_o == exp, req, $sformatf("op %0d fmt %0d", op, fmt), result_o, exp);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired: actual running expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    logic [127:0] held;
    repeat (3) @(negedge clk);
    // R12: reset state
    check(result_o == '0, 12, "result in reset", result_o, 128'd0);
    check(valid_o == 1'b0, 12, "valid in reset", 128'(valid_o), 128'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Directed table
    for (int k = 0; k < NV; k++)
      run_op(VECS[k].op, VECS[k].fmt, VECS[k].a, VECS[k].b, VECS[k].exp, int'(VECS[k].req));

    // R1: no new start -> valid drops, result holds despite changing inputs
    held = result_o;
    @(negedge clk);
    op_i = 5'(OP_ADDS_U); src_a_i = {16{8'h11}}; src_b_i = {16{8'h22}};
    @(negedge clk);
    check(valid_o == 1'b0, 1, "valid low without start", 128'(valid_o), 128'd0);
    check(result_o == held, 1, "result held without start", result_o, held);

    // R2: distinct lanes, no cross-lane carry, all formats
    run_op(5'(OP_ADDS_U), 2'd0, {8'hff, 8'h01, {14{8'h10}}}, {8'h01, 8'h02, {14{8'h01}}},
           {8'hff, 8'h03, {14{8'h11}}}, 2);
    run_op(5'(OP_ADDS_S), 2'd2, {32'h7fff_ffff, 32'h0000_00ff, 32'h8000_0000, 32'd3},
           {32'd1, 32'd1, 32'hffff_ffff, 32'd4},
           {32'h7fff_ffff, 32'h0000_0100, 32'h8000_0000, 32'd7}, 2);

    // Random and corner operands against the reference model, every code and format
    for (int f = 0; f < 4; f++) begin
      for (int op = 0; op < 26; op++) begin
        for (int k = 0; k < 10; k++) begin
          logic [127:0] ra, rb;
          int req;
          ra = rand_vec(f);
          rb = rand_vec(f);
          if (op <= 3) req = 3;        // R3
          else if (op <= 5) req = 4;   // R4
          else if (op <= 7) req = 5;   // R5
          else if (op <= 11) req = 6;  // R6
          else if (op <= 13) req = 7;  // R7
          else if (op <= 19) req = 8;  // R8
          else if (op <= 23) req = 9;  // R9, R10 corners come from pick()
          else req = 11;               // R11
          run_op(5'(op), 2'(f), ra, rb, ref_vec(op, f, ra, rb), req);
        end
      end
    end

    // R12: reset asserted mid-run clears the outputs at once
    run_op(5'(OP_ADDS_U), 2'd0, {16{8'h05}}, {16{8'h05}}, {16{8'h0a}}, 3);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(result_o == '0, 12, "result after async reset", result_o, 128'd0);
    check(valid_o == 1'b0, 12, "valid after async reset", 128'(valid_o), 128'd0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule